// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when a multi-channel line interface device is held in reset and when it is released. Three things can start a reset. The first is a supply-good indication that starts the power-up sequence. The second is an active-low external reset pin. The third is a self-clearing control bit that the host sets by a register write. Each reset process lasts a set number of reference-clock rising edges. The reference clock is sampled in the free-running oscillator domain of the block. While no reference edges arrive, no reset can complete, and a loss-of-clock flag rises after a programmable number of oscillator cycles without an edge.

A reset request that arrives while a reset is already running reloads the counter with the duration of the new source. When the counter runs out, `in_reset` falls and `reset_done` pulses for one cycle. Registered control outputs give the state of the surrounding logic: default loading of the configuration registers, interrupt source disabling, output enables for the interrupt and reference clock outputs, per-channel transmit clock direction, and the enables for the receive, transmit-line and serial data outputs. A mode strap selects between host-controlled and pin-controlled (hardware) behaviour.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `rst`, in host mode with the supply low, `in_reset` is 1, `irq_oe` and `refclk_oe` are 0, `cfg_dflt_load` and `irq_src_dis` are 1, and every `tclk_in` bit is 1.
- R2: When `supply_ok` is 1, the power-up reset ends after POR_CYC reference rising edges: `in_reset` falls, and `reset_done` is 1 for exactly one cycle. While `supply_ok` is 0, the device stays in reset.
- R3: If no reference rising edge arrives for LOSS_WIN oscillator cycles, `clk_absent` becomes 1 and the running reset does not complete. Once edges return, `clk_absent` clears and the count goes on.
- R4: While `ext_rst_n` is 0, `in_reset` stays 1. After `ext_rst_n` returns to 1, the reset ends after HARD_CYC reference rising edges.
- R5: While `ext_rst_n` is 0, every bit of `rx_oe` and `tx_oe` is 0 and `sdo_oe` is 0. All of them return to 1 after the pin is released, even while the reset is still being counted.
- R6: In host mode, a write to address 1 with data bit 0 set makes `soft_bit` read 1 for one cycle, after which it clears by itself. It starts a reset that ends after SOFT_CYC reference rising edges.
- R7: A write to any other address, a write to address 1 with data bit 0 clear, or any write in hardware mode leaves `soft_bit` at 0 and starts no reset.
- R8: A reset request that arrives during a running reset restarts the count with the full duration of the new source.
- R9: In host mode, while in reset, `irq_oe` and `refclk_oe` are 0 and `cfg_dflt_load` and `irq_src_dis` are 1. Out of reset, `irq_oe` and `refclk_oe` are 1 and the other two are 0.
- R10: In hardware mode, `refclk_oe` is 1 whether or not the device is in reset, `irq_oe` follows `pm_irq_en`, and `cfg_dflt_load` is 0.
- R11: In both modes, every `tclk_in` bit is 1 while in reset and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok | input | 1 | Supply-good indication, starts the power-up reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| host_mode | input | 1 | Mode strap: 1 host-controlled, 0 hardware |
| pm_irq_en | input | 1 | Interrupt output enable used in hardware mode |
| ref_clk_in | input | 1 | Reference clock, sampled in the `clk` domain |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | AW | Host register write address |
| reg_wdata | input | DW | Host register write data |
| in_reset | output | 1 | Device held in reset |
| reset_done | output | 1 | One-cycle pulse when a reset sequence ends |
| clk_absent | output | 1 | Reference clock declared missing |
| soft_bit | output | 1 | Readback of the self-clearing reset bit |
| cfg_dflt_load | output | 1 | Configuration registers load defaults |
| irq_src_dis | output | 1 | All interrupt sources disabled |
| irq_oe | output | 1 | Interrupt output enable |
| refclk_oe | output | 1 | Reference clock outputs enable |
| tclk_in | output | NCH | Per-channel transmit clock pin forced to input |
| rx_oe | output | NCH | Per-channel receive clock and data output enable |
| tx_oe | output | NCH | Per-channel transmit line output enable |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The assertions assume that the mode strap and `pm_irq_en` change only while `rst` is high, and that the host never writes the reset bit on two cycles in a row. They also assume that each phase of the reference clock lasts several oscillator cycles, so that the synchronizer sees every edge. The stimulus changes the strap only inside a `rst` pulse and spaces all writes. It drives a reference clock with a half period of ten oscillator cycles. Each request and each release is placed in the middle of a low phase of the reference clock, so the number of edges that count toward a duration is known exactly.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_SUPPLY_WAIT = 2'd0,
    ST_COUNT       = 2'd1,
    ST_RUN         = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rst_clk_monitor.sv
module rst_clk_monitor #(
  parameter int LOSS_WIN = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_rise,
  output logic ref_absent
);
  localparam int GW = $clog2(LOSS_WIN + 1);

  logic [2:0]    samp;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) samp <= '0;
    else     samp <= {samp[1:0], ref_in};
  end

  assign ref_rise = samp[1] & ~samp[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap        <= '0;
      ref_absent <= 1'b0;
    end else if (ref_rise) begin
      gap        <= '0;
      ref_absent <= 1'b0;
    end else if (gap == GW'(LOSS_WIN)) begin
      ref_absent <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_EDGE_CLEARS_LOSS: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> !ref_absent); // R3
endmodule

// File: rtl/rst_soft_reg.sv
module rst_soft_reg #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SOFT_ADDR = 1,
  parameter int SOFT_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          soft_bit
);
  logic wr_hit;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_hit = host_mode && wr_en && (addr == AW'(SOFT_ADDR)) && wdata[SOFT_BIT];

  always_ff @(posedge clk) begin
    if (rst) soft_bit <= 1'b0;
    else     soft_bit <= wr_hit && !soft_bit;
  end

  AST_SOFT_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_bit |=> !soft_bit); // R6
  AST_SOFT_HW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!$past(host_mode) && !$past(rst)) |-> !soft_bit); // R7
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
  import rst_seq_pkg::*;
#(
  parameter int POR_CYC  = 463200,
  parameter int HARD_CYC = 8,
  parameter int SOFT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic pin_low,
  input  logic soft_req,
  input  logic ref_rise,
  output logic in_reset,
  output logic reset_done
);
  localparam int MAXC = (POR_CYC > HARD_CYC)
                      ? ((POR_CYC > SOFT_CYC) ? POR_CYC : SOFT_CYC)
                      : ((HARD_CYC > SOFT_CYC) ? HARD_CYC : SOFT_CYC);
  localparam int CW = $clog2(MAXC + 1);

  seq_state_t    state;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SUPPLY_WAIT;
      remain     <= CW'(POR_CYC);
      in_reset   <= 1'b1;
      reset_done <= 1'b0;
    end else begin
      reset_done <= 1'b0;
      if (!supply_ok) begin
        state    <= ST_SUPPLY_WAIT;
        remain   <= CW'(POR_CYC);
        in_reset <= 1'b1;
      end else if (state == ST_SUPPLY_WAIT) begin
        state    <= ST_COUNT;
        remain   <= CW'(POR_CYC);
        in_reset <= 1'b1;
      end else if (pin_low) begin
        state    <= ST_COUNT;
        remain   <= CW'(HARD_CYC);
        in_reset <= 1'b1;
      end else if (soft_req) begin
        state    <= ST_COUNT;
        remain   <= CW'(SOFT_CYC);
        in_reset <= 1'b1;
      end else if (state == ST_COUNT && ref_rise) begin
        if (remain == CW'(1)) begin
          state      <= ST_RUN;
          in_reset   <= 1'b0;
          reset_done <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reset_done |=> !reset_done); // R2
  AST_PIN_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
    pin_low |=> in_reset); // R4
  AST_NO_SUPPLY_RESET: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> in_reset); // R2
endmodule

// File: rtl/rst_out_ctrl.sv
module rst_out_ctrl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_mode,
  input  logic           pm_irq_en,
  input  logic           in_reset,
  input  logic           pin_low,
  output logic           cfg_dflt_load,
  output logic           irq_src_dis,
  output logic           irq_oe,
  output logic           refclk_oe,
  output logic [NCH-1:0] tclk_in,
  output logic [NCH-1:0] rx_oe,
  output logic [NCH-1:0] tx_oe,
  output logic           sdo_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_dflt_load <= 1'b0;
      irq_src_dis   <= 1'b0;
      irq_oe        <= 1'b0;
      refclk_oe     <= 1'b0;
      sdo_oe        <= 1'b0;
    end else begin
      cfg_dflt_load <= host_mode && in_reset;
      irq_src_dis   <= host_mode && in_reset;
      irq_oe        <= host_mode ? !in_reset : pm_irq_en;
      refclk_oe     <= host_mode ? !in_reset : 1'b1;
      sdo_oe        <= !pin_low;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        tclk_in[ch] <= 1'b1;
        rx_oe[ch]   <= 1'b0;
        tx_oe[ch]   <= 1'b0;
      end else begin
        tclk_in[ch] <= in_reset;
        rx_oe[ch]   <= !pin_low;
        tx_oe[ch]   <= !pin_low;
      end
    end
  end

  AST_HOST_IRQ_HIZ: assert property (@(posedge clk) disable iff (rst)
    ($past(host_mode) && $past(in_reset) && !$past(rst)) |-> !irq_oe); // R9
  AST_HW_REFCLK_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(host_mode) && !$past(rst)) |-> refclk_oe); // R10
  AST_PIN_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(pin_low) && !$past(rst)) |-> (rx_oe == '0 && tx_oe == '0 && !sdo_oe)); // R5
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int NCH       = 4,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SOFT_ADDR = 1,
  parameter int SOFT_BIT  = 0,
  parameter int POR_CYC   = 463200,
  parameter int HARD_CYC  = 8,
  parameter int SOFT_CYC  = 8,
  parameter int LOSS_WIN  = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           supply_ok,
  input  logic           ext_rst_n,
  input  logic           host_mode,
  input  logic           pm_irq_en,
  input  logic           ref_clk_in,
  input  logic           reg_wr_en,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic           in_reset,
  output logic           reset_done,
  output logic           clk_absent,
  output logic           soft_bit,
  output logic           cfg_dflt_load,
  output logic           irq_src_dis,
  output logic           irq_oe,
  output logic           refclk_oe,
  output logic [NCH-1:0] tclk_in,
  output logic [NCH-1:0] rx_oe,
  output logic [NCH-1:0] tx_oe,
  output logic           sdo_oe
);
  logic [1:0] pin_sync;
  logic       pin_low;
  logic       ref_rise;

  always_ff @(posedge clk) begin
    if (rst) pin_sync <= 2'b11;
    else     pin_sync <= {pin_sync[0], ext_rst_n};
  end
  assign pin_low = !pin_sync[1];

  rst_clk_monitor #(.LOSS_WIN(LOSS_WIN)) u_mon (
    .clk        (clk),
    .rst        (rst),
    .ref_in     (ref_clk_in),
    .ref_rise   (ref_rise),
    .ref_absent (clk_absent)
  );

  rst_soft_reg #(
    .AW(AW), .DW(DW), .SOFT_ADDR(SOFT_ADDR), .SOFT_BIT(SOFT_BIT)
  ) u_soft (
    .clk       (clk),
    .rst       (rst),
    .host_mode (host_mode),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .soft_bit  (soft_bit)
  );

  rst_seq_timer #(
    .POR_CYC(POR_CYC), .HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .pin_low    (pin_low),
    .soft_req   (soft_bit),
    .ref_rise   (ref_rise),
    .in_reset   (in_reset),
    .reset_done (reset_done)
  );

  rst_out_ctrl #(.NCH(NCH)) u_out (
    .clk           (clk),
    .rst           (rst),
    .host_mode     (host_mode),
    .pm_irq_en     (pm_irq_en),
    .in_reset      (in_reset),
    .pin_low       (pin_low),
    .cfg_dflt_load (cfg_dflt_load),
    .irq_src_dis   (irq_src_dis),
    .irq_oe        (irq_oe),
    .refclk_oe     (refclk_oe),
    .tclk_in       (tclk_in),
    .rx_oe         (rx_oe),
    .tx_oe         (tx_oe),
    .sdo_oe        (sdo_oe)
  );

  AST_NO_DONE_WHEN_ABSENT: assert property (@(posedge clk) disable iff (rst)
    clk_absent |-> !reset_done); // R3
  AST_DONE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    reset_done |-> ($past(in_reset) && !in_reset)); // R2
endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic ext_rst_n = 1'b1;
  logic host_mode = 1'b1;
  logic pm_irq_en = 1'b0;
  logic ref_clk_in = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic in_reset, reset_done, clk_absent, soft_bit;
  logic cfg_dflt_load, irq_src_dis, irq_oe, refclk_oe, sdo_oe;
  logic [NCH-1:0] tclk_in, rx_oe, tx_oe;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int div = 0;
  bit ref_run = 1'b0;
  bit finished = 1'b0;

  rst_seq_ctrl #(
    .NCH(NCH), .POR_CYC(5), .HARD_CYC(3), .SOFT_CYC(3), .LOSS_WIN(40)
  ) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n),
    .host_mode(host_mode), .pm_irq_en(pm_irq_en), .ref_clk_in(ref_clk_in),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .in_reset(in_reset), .reset_done(reset_done), .clk_absent(clk_absent),
    .soft_bit(soft_bit), .cfg_dflt_load(cfg_dflt_load), .irq_src_dis(irq_src_dis),
    .irq_oe(irq_oe), .refclk_oe(refclk_oe), .tclk_in(tclk_in), .rx_oe(rx_oe),
    .tx_oe(tx_oe), .sdo_oe(sdo_oe)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (ref_run) begin
      if (div == 9) begin
        div = 0;
        ref_clk_in = ~ref_clk_in;
      end else begin
        div = div + 1;
      end
    end
  end

  always @(posedge clk) if (!rst && reset_done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic safe_point();
    @(negedge ref_clk_in);
    repeat (3) @(negedge clk);
  endtask

  task automatic rises(input int n);
    repeat (n) @(posedge ref_clk_in);
    repeat (8) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic t_reset_state();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in_reset", 32'(in_reset), 32'd1);
    chk("R1 irq_oe", 32'(irq_oe), 32'd0);
    chk("R1 refclk_oe", 32'(refclk_oe), 32'd0);
    chk("R1 cfg_dflt_load", 32'(cfg_dflt_load), 32'd1);
    chk("R1 irq_src_dis", 32'(irq_src_dis), 32'd1);
    chk("R1 tclk_in", 32'(tclk_in), 32'hF);
  endtask

  task automatic t_por_no_clock();
    int d0;
    supply_ok = 1'b1;
    d0 = done_cnt;
    repeat (100) @(negedge clk);
    chk("R3 clk_absent set", 32'(clk_absent), 32'd1);
    chk("R3 held in reset", 32'(in_reset), 32'd1);
    chk("R3 no done", 32'(done_cnt - d0), 32'd0);
    ref_run = 1'b1;
    rises(4);
    chk("R3 clk_absent cleared", 32'(clk_absent), 32'd0);
    chk("R2 before last edge", 32'(in_reset), 32'd1);
    chk("R9 irq_oe in reset", 32'(irq_oe), 32'd0);
    rises(1);
    chk("R2 released", 32'(in_reset), 32'd0);
    chk("R2 one done pulse", 32'(done_cnt - d0), 32'd1);
    chk("R9 irq_oe out of reset", 32'(irq_oe), 32'd1);
    chk("R9 refclk_oe out of reset", 32'(refclk_oe), 32'd1);
    chk("R9 cfg_dflt_load cleared", 32'(cfg_dflt_load), 32'd0);
    chk("R11 tclk_in cleared", 32'(tclk_in), 32'd0);
  endtask

  task automatic t_hard();
    int d0;
    safe_point();
    ext_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 in reset", 32'(in_reset), 32'd1);
    chk("R5 rx_oe off", 32'(rx_oe), 32'd0);
    chk("R5 tx_oe off", 32'(tx_oe), 32'd0);
    chk("R5 sdo_oe off", 32'(sdo_oe), 32'd0);
    repeat (60) @(negedge clk);
    chk("R4 held while low", 32'(in_reset), 32'd1);
    safe_point();
    ext_rst_n = 1'b1;
    d0 = done_cnt;
    repeat (5) @(negedge clk);
    chk("R5 rx_oe back", 32'(rx_oe), 32'hF);
    chk("R5 sdo_oe back", 32'(sdo_oe), 32'd1);
    rises(2);
    chk("R4 before last edge", 32'(in_reset), 32'd1);
    rises(1);
    chk("R4 released", 32'(in_reset), 32'd0);
    chk("R4 one done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  task automatic t_soft();
    int d0;
    safe_point();
    d0 = done_cnt;
    host_write(8'h01, 8'h01);
    chk("R6 soft_bit set", 32'(soft_bit), 32'd1);
    @(negedge clk);
    chk("R6 soft_bit self-clears", 32'(soft_bit), 32'd0);
    rises(2);
    chk("R6 before last edge", 32'(in_reset), 32'd1);
    chk("R11 tclk_in in reset", 32'(tclk_in), 32'hF);
    chk("R9 refclk_oe in reset", 32'(refclk_oe), 32'd0);
    rises(1);
    chk("R6 released", 32'(in_reset), 32'd0);
    chk("R6 one done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  task automatic t_restart();
    int d0;
    safe_point();
    host_write(8'h01, 8'h01);
    rises(1);
    safe_point();
    d0 = done_cnt;
    host_write(8'h01, 8'h01);
    rises(2);
    chk("R8 restarted count", 32'(in_reset), 32'd1);
    chk("R8 no early done", 32'(done_cnt - d0), 32'd0);
    rises(1);
    chk("R8 released", 32'(in_reset), 32'd0);
    chk("R8 one done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  task automatic t_ignored_host();
    int d0;
    safe_point();
    d0 = done_cnt;
    host_write(8'h02, 8'h01);
    chk("R7 other address", 32'(soft_bit), 32'd0);
    host_write(8'h01, 8'h02);
    chk("R7 bit clear", 32'(soft_bit), 32'd0);
    repeat (80) @(negedge clk);
    chk("R7 no reset", 32'(in_reset), 32'd0);
    chk("R7 no done", 32'(done_cnt - d0), 32'd0);
  endtask

  task automatic t_hw_mode();
    int d0;
    @(negedge ref_clk_in);
    rst = 1'b1;
    host_mode = 1'b0;
    pm_irq_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    d0 = done_cnt;
    rises(4);
    chk("R10 refclk_oe in reset", 32'(refclk_oe), 32'd1);
    chk("R10 irq_oe follows pm", 32'(irq_oe), 32'd0);
    chk("R10 cfg_dflt_load", 32'(cfg_dflt_load), 32'd0);
    chk("R11 tclk_in hw reset", 32'(tclk_in), 32'hF);
    rises(1);
    chk("R2 hw released", 32'(in_reset), 32'd0);
    chk("R2 hw one done", 32'(done_cnt - d0), 32'd1);
    chk("R11 tclk_in hw run", 32'(tclk_in), 32'd0);
    pm_irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 irq_oe follows pm high", 32'(irq_oe), 32'd1);
    safe_point();
    d0 = done_cnt;
    host_write(8'h01, 8'h01);
    chk("R7 hw write ignored", 32'(soft_bit), 32'd0);
    repeat (80) @(negedge clk);
    chk("R7 hw no reset", 32'(in_reset), 32'd0);
    chk("R7 hw no done", 32'(done_cnt - d0), 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_por_no_clock();
    t_hard();
    t_soft();
    t_restart();
    t_ignored_host();
    t_hw_mode();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule